// File: doc/BRIEF.md
# Hub Port Change Bitmap Reporter

This block keeps the change bitmap of a four-port hub and answers the host's periodic polls on the hub's interrupt endpoint. Bit 0 records a change of hub-wide status. Bits 1 to 4 record changes on downstream ports 1 to 4. One-cycle event pulses from the hub logic and from each port set these bits. The bits are sticky. A bit clears only when the control-request decoder reports that the host has cleared that particular change.

Each IN token aimed at the interrupt endpoint arrives as a decoded strobe. One cycle later the block answers with exactly one strobe. It gives a NAK strobe when there is nothing to report, or when the device is not configured. Otherwise it gives a data strobe together with the whole byte. Sending the byte leaves the bitmap unchanged. A data toggle for the endpoint flips on every host ACK of a data packet. The toggle returns to DATA0 whenever the device is not configured.

A small state machine sequences the endpoint. Its states are:
- `ST_UNCFG`: the device is not configured.
- `ST_IDLE`: configured, with no data packet outstanding.
- `ST_AWAIT_ACK`: a data packet was sent and its handshake is pending.

Its transitions are:
- Any state goes to `ST_UNCFG` when the configured flag is low.
- `ST_UNCFG` goes to `ST_IDLE` on the first configured cycle.
- `ST_IDLE` goes to `ST_AWAIT_ACK` when a poll is answered with data.
- `ST_AWAIT_ACK` goes back to `ST_IDLE` on an ACK, or when a new poll is answered with NAK.
- `ST_AWAIT_ACK` stays where it is when a new poll is answered with data. This is a retry, and the toggle does not change.

Top module: `hubchg_reporter`

## Requirements
- R1: A pulse on `hub_evt_i` sets bitmap bit 0. A pulse on `port_evt_i[k-1]` sets bitmap bit k, for k = 1 to 4.
- R2: Bitmap bits 5 to 7 always read as zero. After reset the bitmap is zero, and `nak_o`, `dval_o`, `data_o` and `toggle_o` are all 0.
- R3: An accepted poll with bitmap bits 0 to 4 all zero gives `nak_o`=1 and `dval_o`=0 in the cycle after `in_tok_i`.
- R4: An accepted poll with any of bits 0 to 4 set gives `dval_o`=1, `nak_o`=0 and `data_o` equal to the bitmap byte in the cycle after `in_tok_i`. In all other cycles `data_o` is 0.
- R5: Sending the byte clears no bit. A set bit is reported on every later poll until its own clear input (`clr_hub_i` for bit 0, `clr_port_i[k-1]` for bit k) pulses. A clear pulse for one bit leaves the other bits unchanged.
- R6: When a set pulse and a clear pulse for the same bit arrive in the same cycle, the bit ends up set.
- R7: While `configured_i` is 0, every poll is answered with NAK and event pulses are not recorded. A poll in the first cycle that `configured_i` is 1 after being 0 is also answered with NAK.
- R8: A cycle with `configured_i` at 0 clears the whole bitmap, and the toggle reads 0 from the next cycle on.
- R9: `toggle_o` is the DATA0(0)/DATA1(1) toggle for the next data packet. It flips on `ack_i` only while a data packet is awaiting its handshake. A NAK, a retry, or an `ack_i` with nothing outstanding leaves it unchanged.
- R10: Every `in_tok_i` pulse produces exactly one of `nak_o` or `dval_o` one cycle later. Neither strobe appears in any other cycle. The byte holds the bitmap as it stood before the token cycle, so an event in the token cycle shows only on the next poll.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| configured_i | input | 1 | Device enumerated and configured |
| hub_evt_i | input | 1 | Hub-level status change pulse |
| port_evt_i | input | 4 | Per-port status change pulses, bit k-1 for port k |
| clr_hub_i | input | 1 | Host cleared the hub-level change |
| clr_port_i | input | 4 | Host cleared the change of port k (bit k-1) |
| in_tok_i | input | 1 | IN token for the interrupt endpoint |
| ack_i | input | 1 | Host ACK handshake for the interrupt endpoint |
| nak_o | output | 1 | Send NAK handshake (one-cycle strobe) |
| dval_o | output | 1 | Send one-byte data packet (one-cycle strobe) |
| data_o | output | 8 | Bitmap byte, valid with `dval_o` |
| toggle_o | output | 1 | Data toggle for the next data packet |

## Verification
A wrong bitmap bit shows up on the very next poll. It appears either as a wrong byte or as a NAK in place of data, one cycle after the token. A lost stickiness or a missing clear therefore shows within one poll. A stuck or mis-sequenced state register shows as a missing strobe, a double strobe, or a data strobe while unconfigured, again in the cycle after a token. A toggle error shows as a wrong `toggle_o` in the cycle after the ACK or the configuration drop. The bench sweeps every 5-bit set pattern against every clear pattern, so each bit's set/clear path is checked through the port on each poll.

// File: rtl/hubchg_pkg.sv
package hubchg_pkg;
    typedef enum logic [1:0] {
        ST_UNCFG     = 2'd0,
        ST_IDLE      = 2'd1,
        ST_AWAIT_ACK = 2'd2
    } rep_state_e;
endpackage

// File: rtl/hubchg_bitmap.sv
// Sticky change bits: set wins over clear, all held at zero while disabled.
module hubchg_bitmap #(
    parameter int unsigned CHG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable_i,
    input  logic [CHG_W-1:0] set_i,
    input  logic [CHG_W-1:0] clr_i,
    output logic [CHG_W-1:0] bits_o
);
    logic [CHG_W-1:0] bits_q;

    for (genvar b = 0; b < CHG_W; b++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                bits_q[b] <= 1'b0;
            end else if (!enable_i) begin
                bits_q[b] <= 1'b0;
            end else if (set_i[b]) begin
                bits_q[b] <= 1'b1;
            end else if (clr_i[b]) begin
                bits_q[b] <= 1'b0;
            end
        end
    end

    assign bits_o = bits_q;
endmodule

// File: rtl/hubchg_ctrl.sv
// Endpoint sequencer: NAK / data decision, handshake wait and data toggle.
module hubchg_ctrl
    import hubchg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic configured_i,
    input  logic tok_i,
    input  logic ack_i,
    input  logic any_i,
    output logic give_data_o,
    output logic nak_o,
    output logic dval_o,
    output logic toggle_o
);
    rep_state_e state_q, state_d;
    logic       respond;
    logic       give_data;
    logic       ack_taken;
    logic       nak_q, dval_q, tog_q;

    always_comb begin
        respond   = tok_i && configured_i && (state_q != ST_UNCFG);
        give_data = respond && any_i;
        ack_taken = (state_q == ST_AWAIT_ACK) && ack_i && !tok_i
                    && configured_i;
    end

    always_comb begin
        state_d = state_q;
        if (!configured_i) begin
            state_d = ST_UNCFG;
        end else begin
            unique case (state_q)
                ST_UNCFG: state_d = ST_IDLE;
                ST_IDLE: begin
                    if (give_data) state_d = ST_AWAIT_ACK;
                end
                ST_AWAIT_ACK: begin
                    if (tok_i) begin
                        state_d = give_data ? ST_AWAIT_ACK : ST_IDLE;
                    end else if (ack_i) begin
                        state_d = ST_IDLE;
                    end
                end
                default: state_d = ST_UNCFG;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_UNCFG;
        else        state_q <= state_d;
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nak_q  <= 1'b0;
            dval_q <= 1'b0;
            tog_q  <= 1'b0;
        end else begin
            nak_q  <= tok_i && !give_data;
            dval_q <= give_data;
            if (!configured_i) begin
                tog_q <= 1'b0;
            end else if (ack_taken) begin
                tog_q <= ~tog_q;
            end
        end
    end

    assign give_data_o = give_data;
    assign nak_o       = nak_q;
    assign dval_o      = dval_q;
    assign toggle_o    = tog_q;
endmodule

// File: rtl/hubchg_reporter.sv
module hubchg_reporter #(
    parameter int unsigned NUM_PORTS = 4,
    parameter int unsigned BYTE_W    = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 configured_i,
    input  logic                 hub_evt_i,
    input  logic [NUM_PORTS-1:0] port_evt_i,
    input  logic                 clr_hub_i,
    input  logic [NUM_PORTS-1:0] clr_port_i,
    input  logic                 in_tok_i,
    input  logic                 ack_i,
    output logic                 nak_o,
    output logic                 dval_o,
    output logic [BYTE_W-1:0]    data_o,
    output logic                 toggle_o
);
    localparam int unsigned CHG_W = NUM_PORTS + 1;

    logic [CHG_W-1:0]  bits;
    logic [BYTE_W-1:0] byte_now;
    logic [BYTE_W-1:0] data_q;
    logic              give_data;

    hubchg_bitmap #(.CHG_W(CHG_W)) u_bitmap (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable_i (configured_i),
        .set_i    ({port_evt_i, hub_evt_i}),
        .clr_i    ({clr_port_i, clr_hub_i}),
        .bits_o   (bits)
    );

    hubchg_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .configured_i (configured_i),
        .tok_i        (in_tok_i),
        .ack_i        (ack_i),
        .any_i        (|bits),
        .give_data_o  (give_data),
        .nak_o        (nak_o),
        .dval_o       (dval_o),
        .toggle_o     (toggle_o)
    );

    // Reserved upper bits are tied to zero.
    always_comb begin
        byte_now            = '0;
        byte_now[CHG_W-1:0] = bits;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         data_q <= '0;
        else if (give_data) data_q <= byte_now;
        else                data_q <= '0;
    end

    assign data_o = data_q;
endmodule

// File: rtl/hubchg_checker.sv
module hubchg_checker #(
    parameter int unsigned NUM_PORTS = 4,
    parameter int unsigned BYTE_W    = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              configured_i,
    input logic              in_tok_i,
    input logic              ack_i,
    input logic              nak_o,
    input logic              dval_o,
    input logic [BYTE_W-1:0] data_o,
    input logic              toggle_o
);
    localparam int unsigned CHG_W = NUM_PORTS + 1;

    assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (data_o >> CHG_W) == '0);

    assert_one_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        in_tok_i |=> (nak_o ^ dval_o));

    assert_no_spurious_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_tok_i |=> !(nak_o || dval_o));

    assert_data_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dval_o |-> (data_o[CHG_W-1:0] != '0));

    assert_unconfig_nak_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!configured_i && in_tok_i) |=> nak_o);

    assert_toggle_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !configured_i |=> !toggle_o);

    assert_toggle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (configured_i && !ack_i) |=> $stable(toggle_o));
endmodule

bind hubchg_reporter hubchg_checker #(
    .NUM_PORTS (NUM_PORTS),
    .BYTE_W    (BYTE_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .configured_i (configured_i),
    .in_tok_i     (in_tok_i),
    .ack_i        (ack_i),
    .nak_o        (nak_o),
    .dval_o       (dval_o),
    .data_o       (data_o),
    .toggle_o     (toggle_o)
);

// File: tb/tb_hubchg_reporter.sv
`timescale 1ns/1ps
module tb_hubchg_reporter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       configured_i = 1'b0;
    logic       hub_evt_i = 1'b0;
    logic [3:0] port_evt_i = '0;
    logic       clr_hub_i = 1'b0;
    logic [3:0] clr_port_i = '0;
    logic       in_tok_i = 1'b0;
    logic       ack_i = 1'b0;
    logic       nak_o, dval_o, toggle_o;
    logic [7:0] data_o;

    int checks = 0;
    int errors = 0;
    logic [4:0] exp_bits = '0;
    logic       exp_tog = 1'b0;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    hubchg_reporter dut (
        .clk(clk), .rst_n(rst_n), .configured_i(configured_i),
        .hub_evt_i(hub_evt_i), .port_evt_i(port_evt_i),
        .clr_hub_i(clr_hub_i), .clr_port_i(clr_port_i),
        .in_tok_i(in_tok_i), .ack_i(ack_i),
        .nak_o(nak_o), .dval_o(dval_o), .data_o(data_o), .toggle_o(toggle_o)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One cycle of set/clear pulses (bit0 hub, bits 4:1 ports).
    task automatic pulse(logic [4:0] s, logic [4:0] c);
        hub_evt_i = s[0]; port_evt_i = s[4:1];
        clr_hub_i = c[0]; clr_port_i = c[4:1];
        @(negedge clk);
        hub_evt_i = 1'b0; port_evt_i = '0; clr_hub_i = 1'b0; clr_port_i = '0;
        if (configured_i) exp_bits = s | (exp_bits & ~c);
    endtask

    // Poll; e is the byte expected (0 means NAK). Acks data when ack_it.
    task automatic poll(logic [4:0] e, string req, bit ack_it);
        in_tok_i = 1'b1;
        @(negedge clk);
        in_tok_i = 1'b0;
        if (e == 0) begin
            chk({req, " nak"}, {31'd0, nak_o}, 32'd1);
            chk({req, " dval"}, {31'd0, dval_o}, 32'd0);
        end else begin
            chk({req, " dval"}, {31'd0, dval_o}, 32'd1);
            chk({req, " nak"}, {31'd0, nak_o}, 32'd0);
            chk({req, " data"}, {24'd0, data_o}, {27'd0, e});
            chk({req, " toggle R9"}, {31'd0, toggle_o}, {31'd0, exp_tog});
            if (ack_it) begin
                ack_i = 1'b1;
                @(negedge clk);
                ack_i = 1'b0;
                exp_tog = ~exp_tog;
                chk("R9 toggle after ack", {31'd0, toggle_o}, {31'd0, exp_tog});
                chk("R10 quiet", {30'd0, nak_o, dval_o}, 32'd0);
            end
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R2: reset state
        chk("R2 reset outputs", {21'd0, nak_o, dval_o, data_o, toggle_o}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R7: unconfigured, events ignored, polls NAK
        pulse(5'h1f, 5'h00);
        poll(5'h00, "R7 unconfigured", 1'b0);
        configured_i = 1'b1;
        poll(5'h00, "R7 first configured cycle", 1'b0);
        poll(5'h00, "R7 events not recorded", 1'b0);
        chk("R8 toggle DATA0 on configure", {31'd0, toggle_o}, 32'd0);

        // R1: individual bit mapping
        for (int b = 0; b < 5; b++) begin
            pulse(5'(1 << b), 5'h00);
            poll(5'(1 << b), "R1 bit map", 1'b1);
            pulse(5'h00, 5'(1 << b));
            poll(5'h00, "R3 cleared", 1'b0);
        end

        // R5/R3/R4: exhaustive set x clear sweep
        for (int p = 0; p < 32; p++) begin
            for (int c = 0; c < 32; c++) begin
                pulse(5'h00, 5'h1f);
                pulse(5'(p), 5'h00);
                poll(exp_bits, "R4 set pattern", (c[0] == 1'b1));
                poll(exp_bits, "R5 sticky repoll", 1'b1);
                pulse(5'h00, 5'(c));
                chk("R5 model", {27'd0, exp_bits}, 32'(p & ~c));
                poll(exp_bits, "R5 partial clear", 1'b1);
            end
        end

        // R6: set and clear same cycle
        pulse(5'h00, 5'h1f);
        pulse(5'h0a, 5'h0a);
        poll(5'h0a, "R6 set wins", 1'b1);

        // R9: ack with nothing outstanding, NAK then ack
        pulse(5'h00, 5'h1f);
        poll(5'h00, "R9 nak", 1'b0);
        ack_i = 1'b1; @(negedge clk); ack_i = 1'b0;
        chk("R9 stray ack ignored", {31'd0, toggle_o}, {31'd0, exp_tog});

        // R9: retry without ack keeps toggle
        pulse(5'h04, 5'h00);
        poll(5'h04, "R9 first send", 1'b0);
        poll(5'h04, "R9 retry same toggle", 1'b1);

        // R10: event in token cycle appears on next poll only
        pulse(5'h00, 5'h1f);
        in_tok_i = 1'b1; port_evt_i = 4'b1000;
        @(negedge clk);
        in_tok_i = 1'b0; port_evt_i = '0;
        chk("R10 token-cycle event not in reply", {31'd0, nak_o}, 32'd1);
        exp_bits = 5'h10;
        poll(5'h10, "R10 event seen next poll", 1'b1);

        // R8: configuration drop clears bitmap and toggle
        if (!exp_tog) poll(5'h10, "R8 prep", 1'b1);
        chk("R8 toggle is 1 before drop", {31'd0, toggle_o}, 32'd1);
        configured_i = 1'b0;
        @(negedge clk);
        chk("R8 toggle cleared", {31'd0, toggle_o}, 32'd0);
        exp_tog = 1'b0;
        configured_i = 1'b1;
        @(negedge clk);
        exp_bits = '0;
        poll(5'h00, "R8 bitmap cleared", 1'b0);
        pulse(5'h03, 5'h00);
        poll(5'h03, "R8 DATA0 after reconfigure", 1'b1);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule